// File: doc/BRIEF.md
# DMA channel command/state controller

This block is the per-channel control word of a descriptor-driven DMA channel, together with the state machine behind it. Software writes a command code into one byte of a 32-bit control word. It reads the channel's present state from a different byte of the same word. The command byte is write-only and always reads back as zero.

Commands that change the channel's state do not take effect at once. The controller first waits until the transfer engine reports that it is idle. The idle condition must then hold for a fixed number of clock cycles, set by a parameter. Until that settle window closes, reads return the old state, so software polls the state byte until it shows the value it asked for.

Apart from commands, three inputs move the channel:
- A work-pending input moves an enabled channel into a running state.
- The engine-idle input returns a running channel to the enabled state once no work remains.
- An external manager-stop input forces the channel into a stopped state, and only a reset command leaves that state.

Top module: `dmac_chan_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000. The state byte (bits 15:8) shows 0 (disabled), and the command byte (bits 23:16) and all other bits read zero.
- R2: The enable command (code 1 in bits 23:16) is accepted from state 0 or state 3. State 1 (enabled) appears exactly SETTLE_CYC clock edges after the accepting edge when engine_idle stays high.
- R3: In state 1 with no command pending, work_pending high moves the state to 2 (running) at the next edge. In state 2 with no command pending, engine_idle high together with work_pending low returns the state to 1 at the next edge.
- R4: The suspend command (code 2) is accepted from state 1 or 2 and leads to state 3 (suspended). The change waits until engine_idle has been high on SETTLE_CYC consecutive edges, and any edge with engine_idle low restarts that count.
- R5: The disable command (code 0) is accepted from states 1, 2 and 3 and leads to state 0 under the same settle rule as R4.
- R6: The reset command (code 9) is accepted from every state and leads to state 0 under the same settle rule as R4. While a reset is pending, manager_stop has no effect.
- R7: manager_stop high in state 1, 2 or 3, with no reset pending, gives state 4 (stopped) at the next edge and cancels any pending non-reset command. manager_stop has no effect in states 0 and 4.
- R8: In state 4 the enable, suspend and disable commands are ignored, so only reset leaves that state.
- R9: A command code other than 0, 1, 2 or 9 is ignored. A defined command that is not legal in the present state is also ignored. In both cases the state is unchanged.
- R10: While an accepted command is settling, reads return the previous state, and further command writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control word |
| csr_wdata | input | DATA_W | Write data; the command code sits at bits CMD_LSB+FIELD_W-1:CMD_LSB |
| csr_rdata | output | DATA_W | Read data; the state code sits at bits STATE_LSB+FIELD_W-1:STATE_LSB, all else zero |
| work_pending | input | 1 | Descriptors are waiting to be processed |
| engine_idle | input | 1 | The transfer engine has no transfer in flight |
| manager_stop | input | 1 | External request to force the channel into the stopped state |

## Verification
The hardest situation to reach is a suspend that is waiting on a busy engine while the idle signal pulses for one cycle and then drops, so the settle count must restart rather than complete. The stimulus holds engine_idle low across the command write and beyond twice the settle window. It then raises idle for a single edge, lowers it, and finally holds it high for exactly the window. A second rare case is manager_stop arriving while a command is pending: a pending reset must block the stop, while a pending suspend must be cancelled by it. The bench therefore raises the stop on the cycle right after each of those writes, with idle held low so that the command is certainly still pending.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_ARMED  = 3'd1,
      ST_BUSY   = 3'd2,
      ST_PAUSED = 3'd3,
      ST_HALTED = 3'd4
   } chan_state_e;

   localparam int unsigned OP_OFF   = 0;
   localparam int unsigned OP_ON    = 1;
   localparam int unsigned OP_PAUSE = 2;
   localparam int unsigned OP_CLEAR = 9;

   typedef struct packed {
      logic        valid;
      logic        is_clear;
      chan_state_e target;
   } cmd_req_t;

   function automatic logic is_live(chan_state_e s);
      return (s == ST_ARMED) || (s == ST_BUSY) || (s == ST_PAUSED);
   endfunction

endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode
   import dmac_pkg::*;
#(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               wr_en,
   input  logic [FIELD_W-1:0] code,
   input  chan_state_e        cur_state,
   input  logic               busy,
   output cmd_req_t           req
);

   logic is_off, is_on, is_pause, is_clear;

   always_comb begin
      is_off   = (code == FIELD_W'(OP_OFF));
      is_on    = (code == FIELD_W'(OP_ON));
      is_pause = (code == FIELD_W'(OP_PAUSE));
      is_clear = (code == FIELD_W'(OP_CLEAR));
   end

   always_comb begin
      req.valid    = 1'b0;
      req.is_clear = 1'b0;
      req.target   = ST_OFF;
      if (wr_en && !busy) begin
         if (is_clear) begin
            req.valid    = 1'b1;
            req.is_clear = 1'b1;
            req.target   = ST_OFF;
         end else if (is_on) begin
            req.valid  = (cur_state == ST_OFF) || (cur_state == ST_PAUSED);
            req.target = ST_ARMED;
         end else if (is_off) begin
            req.valid  = is_live(cur_state);
            req.target = ST_OFF;
         end else if (is_pause) begin
            req.valid  = (cur_state == ST_ARMED) || (cur_state == ST_BUSY);
            req.target = ST_PAUSED;
         end
      end
   end

endmodule

// File: rtl/dmac_settle_timer.sv
module dmac_settle_timer #(
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   input  logic engine_idle,
   output logic pending,
   output logic done
);

   logic pend_q;
   assign pending = pend_q;

   generate
      if (SETTLE_CYC == 1) begin : g_direct
         assign done = pend_q && engine_idle;
      end else begin : g_count
         localparam int unsigned CW = $clog2(SETTLE_CYC);
         localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
         logic [CW-1:0] cnt_q;

         assign done = pend_q && engine_idle && (cnt_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (start) begin
               cnt_q <= '0;
            end else if (pend_q) begin
               if (engine_idle && !done) cnt_q <= cnt_q + 1'b1;
               else                      cnt_q <= '0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (start)  pend_q <= 1'b1;
      else if (abort)  pend_q <= 1'b0;
      else if (done)   pend_q <= 1'b0;
   end

endmodule

// File: rtl/dmac_state_core.sv
module dmac_state_core
   import dmac_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  cmd_req_t    req,
   input  logic        tmr_pending,
   input  logic        tmr_done,
   input  logic        manager_stop,
   input  logic        work_pending,
   input  logic        engine_idle,
   output chan_state_e state,
   output logic        start,
   output logic        stop_take
);

   chan_state_e st_q, st_d, tgt_q;
   logic        clr_q;

   always_comb begin
      stop_take = manager_stop && is_live(st_q)
                  && !(tmr_pending && clr_q)
                  && !(req.valid && req.is_clear);
      start     = req.valid && !stop_take;
   end

   always_comb begin
      st_d = st_q;
      if (stop_take) begin
         st_d = ST_HALTED;
      end else if (tmr_done) begin
         st_d = tgt_q;
      end else if (!tmr_pending) begin
         case (st_q)
            ST_ARMED: if (work_pending)                 st_d = ST_BUSY;
            ST_BUSY:  if (engine_idle && !work_pending) st_d = ST_ARMED;
            default:  st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         tgt_q <= ST_OFF;
         clr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start) begin
            tgt_q <= req.target;
            clr_q <= req.is_clear;
         end
      end
   end

   assign state = st_q;

endmodule

// File: rtl/dmac_chan_ctrl.sv
module dmac_chan_ctrl
   import dmac_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned CMD_LSB    = 16,
   parameter int unsigned STATE_LSB  = 8,
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              work_pending,
   input  logic              engine_idle,
   input  logic              manager_stop
);

   localparam int unsigned CMD_MSB   = CMD_LSB + FIELD_W - 1;
   localparam int unsigned STATE_MSB = STATE_LSB + FIELD_W - 1;

   generate
      if (FIELD_W < 4) begin : g_bad_field
         $error("FIELD_W must hold command code 9");
      end
      if ((CMD_MSB >= DATA_W) || (STATE_MSB >= DATA_W)) begin : g_bad_pos
         $error("command or state field exceeds DATA_W");
      end
      if (!((CMD_LSB > STATE_MSB) || (STATE_LSB > CMD_MSB))) begin : g_overlap
         $error("command and state fields overlap");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [FIELD_W-1:0] code;
   cmd_req_t           req;
   chan_state_e        state;
   logic               tmr_pending, tmr_done, start, stop_take;

   assign code = csr_wdata[CMD_LSB +: FIELD_W];

   dmac_cmd_decode #(.FIELD_W(FIELD_W)) u_dec (
      .wr_en     (csr_wr),
      .code      (code),
      .cur_state (state),
      .busy      (tmr_pending),
      .req       (req)
   );

   dmac_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .abort       (stop_take),
      .engine_idle (engine_idle),
      .pending     (tmr_pending),
      .done        (tmr_done)
   );

   dmac_state_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .tmr_pending  (tmr_pending),
      .tmr_done     (tmr_done),
      .manager_stop (manager_stop),
      .work_pending (work_pending),
      .engine_idle  (engine_idle),
      .state        (state),
      .start        (start),
      .stop_take    (stop_take)
   );

   always_comb begin
      csr_rdata = '0;
      csr_rdata[STATE_LSB +: FIELD_W] = FIELD_W'(state);
   end

endmodule

// File: rtl/dmac_chan_ctrl_chk.sv
module dmac_chan_ctrl_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FIELD_W   = 8,
   parameter int unsigned STATE_LSB = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              work_pending,
   input logic              engine_idle,
   input logic              manager_stop
);

   logic [FIELD_W-1:0] st;
   assign st = csr_rdata[STATE_LSB +: FIELD_W];

   AST_STATE_ENCODED: assert property (@(posedge clk) disable iff (!rst_n)
      st <= FIELD_W'(4)); // R9

   AST_RUN_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(2) && $past(st) == FIELD_W'(1)) |-> $past(work_pending)); // R3

   AST_PAUSE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(3) && $past(st) != FIELD_W'(3)) |-> $past(engine_idle)); // R4

   AST_HALT_VIA_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FIELD_W'(4) && $past(st) != FIELD_W'(4)) |-> $past(manager_stop)); // R7

   AST_HALT_EXIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == FIELD_W'(4)) |-> (st == FIELD_W'(4) || st == FIELD_W'(0))); // R8

endmodule

bind dmac_chan_ctrl dmac_chan_ctrl_chk #(
   .DATA_W    (DATA_W),
   .FIELD_W   (FIELD_W),
   .STATE_LSB (STATE_LSB)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_rdata    (csr_rdata),
   .work_pending (work_pending),
   .engine_idle  (engine_idle),
   .manager_stop (manager_stop)
);

// File: tb/tb_dmac_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dmac_chan_ctrl;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        work_pending = 1'b0;
   logic        engine_idle = 1'b1;
   logic        manager_stop = 1'b0;

   always #4 clk = ~clk;

   dmac_chan_ctrl #(.SETTLE_CYC(LAT)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_wr       (csr_wr),
      .csr_wdata    (csr_wdata),
      .csr_rdata    (csr_rdata),
      .work_pending (work_pending),
      .engine_idle  (engine_idle),
      .manager_stop (manager_stop)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   int m_state = 0, m_pend = 0, m_tgt = 0, m_clr = 0, m_cnt = 0;

   function automatic int legal_tgt(int c, int s);
      if (c == 9) return 0;
      if (c == 1 && (s == 0 || s == 3)) return 1;
      if (c == 0 && (s >= 1 && s <= 3)) return 0;
      if (c == 2 && (s == 1 || s == 2)) return 3;
      return -1;
   endfunction

   always @(posedge clk) begin : mdl
      int  code, t, nst;
      bit  acc, clr_now, stop, done;
      if (!rst_n) begin
         m_state = 0; m_pend = 0; m_tgt = 0; m_clr = 0; m_cnt = 0;
      end else begin
         code    = csr_wr ? int'(csr_wdata[23:16]) : -1;
         t       = (csr_wr && m_pend == 0) ? legal_tgt(code, m_state) : -1;
         acc     = (t >= 0);
         clr_now = acc && (code == 9);
         stop    = manager_stop && (m_state >= 1 && m_state <= 3)
                   && !(m_pend != 0 && m_clr != 0) && !clr_now;
         done    = (m_pend != 0) && engine_idle && (m_cnt == LAT - 1);
         nst     = m_state;
         if (stop) nst = 4;
         else if (done) nst = m_tgt;
         else if (m_pend == 0) begin
            if (m_state == 1 && work_pending) nst = 2;
            else if (m_state == 2 && engine_idle && !work_pending) nst = 1;
         end
         if (acc && !stop) begin
            m_pend = 1; m_cnt = 0; m_tgt = t; m_clr = clr_now ? 1 : 0;
         end else if (stop || done) begin
            m_pend = 0;
         end else if (m_pend != 0) begin
            m_cnt = engine_idle ? m_cnt + 1 : 0;
         end
         m_state = nst;
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) chk(csr_rdata, 32'(m_state) << 8, "R10 per-cycle model");
   end

   task automatic expect_st(input int s, input string tag);
      chk(csr_rdata, 32'(s) << 8, tag);
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_cmd(input logic [7:0] c);
      csr_wr    = 1'b1;
      csr_wdata = {8'hA5, c, 16'h5AC3};
      @(negedge clk);
      csr_wr    = 1'b0;
      csr_wdata = '0;
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      expect_st(0, "R1 reset state");
      tick(1);

      wr_cmd(8'd5);  tick(LAT + 1); expect_st(0, "R9 undefined code 5");
      wr_cmd(8'hFF); tick(LAT + 1); expect_st(0, "R9 undefined code FF");
      wr_cmd(8'd2);  tick(LAT + 1); expect_st(0, "R9 suspend illegal in disabled");
      manager_stop = 1'b1; tick(1); manager_stop = 1'b0;
      expect_st(0, "R7 stop ignored while disabled");

      wr_cmd(8'd1); tick(LAT - 1); expect_st(0, "R10 old state while settling");
      tick(1); expect_st(1, "R2 enable after settle");

      work_pending = 1'b1; tick(1); expect_st(2, "R3 enabled to running");
      work_pending = 1'b0; tick(1); expect_st(1, "R3 running to enabled");
      work_pending = 1'b1; tick(1); expect_st(2, "R3 running again");

      engine_idle = 1'b0; work_pending = 1'b0;
      wr_cmd(8'd2); tick(2 * LAT); expect_st(2, "R4 suspend waits for idle");
      wr_cmd(8'd0); tick(1);
      engine_idle = 1'b1; tick(1); engine_idle = 1'b0; tick(1);
      expect_st(2, "R4 idle drop restarts count");
      engine_idle = 1'b1; tick(LAT - 1); expect_st(2, "R4 still settling");
      tick(1); expect_st(3, "R4 suspended");
      tick(2); expect_st(3, "R10 write during pending ignored");

      wr_cmd(8'd1); tick(LAT); expect_st(1, "R2 resume from suspended");
      wr_cmd(8'd0); tick(LAT); expect_st(0, "R5 disable");

      wr_cmd(8'd1); tick(LAT); expect_st(1, "R2 enable again");
      manager_stop = 1'b1; tick(1); manager_stop = 1'b0;
      expect_st(4, "R7 stop from enabled");
      wr_cmd(8'd1); tick(LAT + 1); expect_st(4, "R8 enable ignored when stopped");
      wr_cmd(8'd2); tick(LAT + 1); expect_st(4, "R8 suspend ignored when stopped");
      wr_cmd(8'd0); tick(LAT + 1); expect_st(4, "R8 disable ignored when stopped");
      wr_cmd(8'd9); tick(LAT - 1); expect_st(4, "R10 old state during reset");
      tick(1); expect_st(0, "R6 reset leaves stopped");

      wr_cmd(8'd1); tick(LAT); expect_st(1, "R2 enable before reset test");
      engine_idle = 1'b0;
      wr_cmd(8'd9);
      manager_stop = 1'b1; tick(1); manager_stop = 1'b0;
      expect_st(1, "R6 stop blocked by pending reset");
      engine_idle = 1'b1; tick(LAT - 1); expect_st(1, "R6 reset settling");
      tick(1); expect_st(0, "R6 reset to disabled");

      wr_cmd(8'd1); tick(LAT); expect_st(1, "R2 enable before cancel test");
      engine_idle = 1'b0;
      wr_cmd(8'd2);
      manager_stop = 1'b1; tick(1); manager_stop = 1'b0;
      expect_st(4, "R7 stop with suspend pending");
      engine_idle = 1'b1; tick(LAT + 2);
      expect_st(4, "R7 pending suspend cancelled");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule